// File: doc/BRIEF.md
# Per-Bit GPIO Interrupt Detector

This block watches one bank of serially sampled general-purpose inputs and turns their changes into interrupts. Once per frame the surrounding logic presents a freshly sampled input word together with a one-cycle valid strobe. The block keeps that word and the one before it. Each bit has its own trigger rule, selected by three configuration words: falling edge, rising edge, either edge, high level or low level.

Each firing sets a sticky status bit. Software clears a status bit by writing one to it. A single combined interrupt line is raised whenever an enabled status bit is set. Software uses a simple register port: a write strobe, a byte address and a data word. A read data word is returned combinationally for the addressed register. The bank width is a parameter, with a default of 32.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the enable word, the three mode words (mode_a, mode_b, mode_c) and the status word all read zero, and irq_o is low.
- R2: Registers sit at byte addresses 0x00 enable, 0x04 mode_a, 0x08 mode_b, 0x0C mode_c and 0x10 status, and read back through rd_data_o. A write to any other address changes no register, and a read of any other address returns zero.
- R3: With mode_b=0, mode_c=0 and mode_a=0, a bit fires when it goes from 1 in the previous sample to 0 in the new one. Its status bit is set on the clock edge after the edge that accepts the sample.
- R4: With mode_b=0, mode_c=0 and mode_a=1, a bit fires only on a 0-to-1 change between consecutive samples. A 1-to-0 change has no effect on its status.
- R5: With mode_b=0 and mode_c=1, a bit fires on any change between consecutive samples, whatever the value of mode_a.
- R6: With mode_b=1, a bit is level-triggered: it fires on every cycle in which the held sample bit equals mode_a (1 means high, 0 means low).
- R7: Writing the status address clears each status bit written with 1 and leaves each bit written with 0 unchanged.
- R8: When a bit fires in the same cycle as a write-one clear of that bit, the status bit stays set.
- R9: Status bits latch whether or not they are enabled. irq_o is high exactly when some status bit and its enable bit are both 1.
- R10: The first sample accepted after reset produces no edge event. Level triggering only acts once a first sample has been accepted.
- R11: Edge events come only from an accepted sample. In cycles without a new sample, edge-mode status bits that are clear stay clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | One-cycle strobe: a new sampled word is present |
| smp_data_i | input | WIDTH | Sampled input word |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | WIDTH | Register write data |
| rd_data_o | output | WIDTH | Read data for reg_addr_i |
| status_o | output | WIDTH | Current status word |
| irq_o | output | 1 | Combined interrupt |

## Verification
The main function is tried with sample sequences that move different groups of bits in opposite directions at the same time. These show whether falling, rising and both-edge bits each fire only on the change they select. A steady held word under level modes separates level detection from edge detection, because it must keep firing with no new sample at all. A write-one clear issued in the exact cycle a bit fires shows which of set and clear wins. Idle stretches and the very first sample after reset show that no event appears without a pair of real samples.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_EN     = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE_A = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_MODE_B = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_MODE_C = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h10;

  typedef enum logic [2:0] {
    TRIG_FALL,
    TRIG_RISE,
    TRIG_BOTH,
    TRIG_LVL_LO,
    TRIG_LVL_HI
  } trig_e;

  // mode_b picks level over edge; mode_c widens an edge to both directions
  function automatic trig_e decode_trig(input logic a, input logic b, input logic c);
    if (b)      return a ? TRIG_LVL_HI : TRIG_LVL_LO;
    else if (c) return TRIG_BOTH;
    else        return a ? TRIG_RISE : TRIG_FALL;
  endfunction
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  en_o,
  output logic [WIDTH-1:0]  mode_a_o,
  output logic [WIDTH-1:0]  mode_b_o,
  output logic [WIDTH-1:0]  mode_c_o,
  output logic [WIDTH-1:0]  clr_o
);
  logic [WIDTH-1:0] en_q, mode_a_q, mode_b_q, mode_c_q;
  logic hit_en, hit_a, hit_b, hit_c, hit_st, hit_any;

  assign hit_en  = we_i && (addr_i == OFS_EN);
  assign hit_a   = we_i && (addr_i == OFS_MODE_A);
  assign hit_b   = we_i && (addr_i == OFS_MODE_B);
  assign hit_c   = we_i && (addr_i == OFS_MODE_C);
  assign hit_st  = we_i && (addr_i == OFS_STAT);
  assign hit_any = hit_en | hit_a | hit_b | hit_c | hit_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      mode_a_q <= '0;
      mode_b_q <= '0;
      mode_c_q <= '0;
    end else begin
      if (hit_en) en_q     <= wdata_i;
      if (hit_a)  mode_a_q <= wdata_i;
      if (hit_b)  mode_b_q <= wdata_i;
      if (hit_c)  mode_c_q <= wdata_i;
    end
  end

  assign clr_o    = hit_st ? wdata_i : '0;
  assign en_o     = en_q;
  assign mode_a_o = mode_a_q;
  assign mode_b_o = mode_b_q;
  assign mode_c_o = mode_c_q;

  p_unmapped_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit_any) |=> ($stable(en_q) && $stable(mode_a_q) &&
                            $stable(mode_b_q) && $stable(mode_c_q)));
endmodule

// File: rtl/gpio_irq_sampler.sv
module gpio_irq_sampler #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o,
  output logic             upd_o,
  output logic             have_o
);
  logic [WIDTH-1:0] cur_q, prev_q;
  logic upd_q, have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
      upd_q  <= 1'b0;
      have_q <= 1'b0;
    end else begin
      upd_q <= valid_i && have_q;  // first sample only arms the pair
      if (valid_i) begin
        prev_q <= cur_q;
        cur_q  <= data_i;
        have_q <= 1'b1;
      end
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
  assign upd_o  = upd_q;
  assign have_o = have_q;

  p_first_sample_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(have_q) |-> !upd_q);
  p_no_sample_no_update_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !upd_q);
endmodule

// File: rtl/gpio_irq_trigger.sv
module gpio_irq_trigger
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic             upd_i,
  input  logic             have_i,
  input  logic [WIDTH-1:0] mode_a_i,
  input  logic [WIDTH-1:0] mode_b_i,
  input  logic [WIDTH-1:0] mode_c_i,
  output logic [WIDTH-1:0] fire_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic  rise, fall;
    trig_e kind;
    assign rise = upd_i &  cur_i[i] & ~prev_i[i];
    assign fall = upd_i & ~cur_i[i] &  prev_i[i];
    assign kind = decode_trig(mode_a_i[i], mode_b_i[i], mode_c_i[i]);
    always_comb begin
      unique case (kind)
        TRIG_FALL:   fire_o[i] = fall;
        TRIG_RISE:   fire_o[i] = rise;
        TRIG_BOTH:   fire_o[i] = rise | fall;
        TRIG_LVL_LO: fire_o[i] = have_i & ~cur_i[i];
        TRIG_LVL_HI: fire_o[i] = have_i &  cur_i[i];
        default:     fire_o[i] = 1'b0;
      endcase
    end
  end

  p_edge_needs_update_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |-> ((fire_o & ~mode_b_i) == '0));
  p_level_needs_sample_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !have_i |-> (fire_o == '0));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] fire_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | fire_i;  // set wins
  end

  assign status_o = status_q;

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(fire_i)) == $past(fire_i)));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(clr_i & ~fire_i)) == '0));
  p_no_spurious_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(fire_i)) == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [WIDTH-1:0]  smp_data_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WIDTH-1:0]  reg_wdata_i,
  output logic [WIDTH-1:0]  rd_data_o,
  output logic [WIDTH-1:0]  status_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] en, mode_a, mode_b, mode_c, clr;
  logic [WIDTH-1:0] cur, prev, fire, status;
  logic upd, have;

  gpio_irq_cfg #(.WIDTH(WIDTH)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .en_o     (en),
    .mode_a_o (mode_a),
    .mode_b_o (mode_b),
    .mode_c_o (mode_c),
    .clr_o    (clr)
  );

  gpio_irq_sampler #(.WIDTH(WIDTH)) u_smp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (smp_valid_i),
    .data_i  (smp_data_i),
    .cur_o   (cur),
    .prev_o  (prev),
    .upd_o   (upd),
    .have_o  (have)
  );

  gpio_irq_trigger #(.WIDTH(WIDTH)) u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cur_i    (cur),
    .prev_i   (prev),
    .upd_i    (upd),
    .have_i   (have),
    .mode_a_i (mode_a),
    .mode_b_i (mode_b),
    .mode_c_i (mode_c),
    .fire_o   (fire)
  );

  gpio_irq_status #(.WIDTH(WIDTH)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .clr_i    (clr),
    .status_o (status)
  );

  always_comb begin
    unique case (reg_addr_i)
      OFS_EN:     rd_data_o = en;
      OFS_MODE_A: rd_data_o = mode_a;
      OFS_MODE_B: rd_data_o = mode_b;
      OFS_MODE_C: rd_data_o = mode_c;
      OFS_STAT:   rd_data_o = status;
      default:    rd_data_o = '0;
    endcase
  end

  assign status_o = status;
  assign irq_o    = |(status & en);

  p_irq_needs_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en != '0));
  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!irq_o && status == '0));
endmodule

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [W-1:0]  smp_data = '0;
  logic          we = 1'b0;
  logic [4:0]    addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rd_data, status;
  logic          irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.WIDTH(W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .smp_valid_i (smp_valid),
    .smp_data_i  (smp_data),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .rd_data_o   (rd_data),
    .status_o    (status),
    .irq_o       (irq)
  );

  // behavioural reference model
  logic [W-1:0] m_en, m_a, m_b, m_c, m_st, m_cur, m_prev;
  bit m_new, m_seen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_a = '0; m_b = '0; m_c = '0; m_st = '0;
      m_cur = '0; m_prev = '0; m_new = 0; m_seen = 0;
    end else begin
      logic [W-1:0] hits, wipe;
      hits = '0;
      for (int i = 0; i < W; i++) begin
        bit went_up, went_dn;
        went_up = m_new && m_cur[i] && !m_prev[i];
        went_dn = m_new && !m_cur[i] && m_prev[i];
        if (m_b[i])      hits[i] = m_seen && (m_cur[i] == m_a[i]);
        else if (m_c[i]) hits[i] = went_up || went_dn;
        else if (m_a[i]) hits[i] = went_up;
        else             hits[i] = went_dn;
      end
      wipe = (we && addr == 5'h10) ? wdata : '0;
      m_st = (m_st & ~wipe) | hits;
      if (we) begin
        case (addr)
          5'h00: m_en = wdata;
          5'h04: m_a  = wdata;
          5'h08: m_b  = wdata;
          5'h0C: m_c  = wdata;
          default: ;
        endcase
      end
      m_new = smp_valid && m_seen;
      if (smp_valid) begin
        m_prev = m_cur; m_cur = smp_data; m_seen = 1;
      end
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      n_run++;
      if (status !== m_st) begin
        n_fail++;
        $display("FAIL R3 model status: actual %h expected %h", status, m_st);
      end
      n_run++;
      if (irq !== (|(m_st & m_en))) begin
        n_fail++;
        $display("FAIL R9 model irq: actual %b expected %b", irq, |(m_st & m_en));
      end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0; addr = 5'h10;
  endtask

  task automatic smp(input logic [W-1:0] d);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [W-1:0] d);
    addr = a;
    #1 d = rd_data;
    addr = 5'h10;
  endtask

  initial begin
    logic [W-1:0] v;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    for (int k = 0; k <= 16; k += 4) begin
      rd(k[4:0], v);
      chk("R1 reset register", v, '0);
    end
    chk("R1 reset irq", {31'd0, irq}, '0);

    // R10 first sample arms only
    smp(32'hFFFF_0000);
    step(2);
    chk("R10 first sample", status, '0);

    // R3 falling edges, R9 latch while disabled
    smp(32'h0F0F_0000);
    step(1);
    chk("R3 falling", status, 32'hF0F0_0000);
    chk("R9 disabled latch irq", {31'd0, irq}, '0);

    // R7 write-one clear, write-zero keep
    wr(5'h10, 32'hF000_0000);
    chk("R7 partial clear", status, 32'h00F0_0000);
    wr(5'h10, 32'h0000_0000);
    chk("R7 zero write keeps", status, 32'h00F0_0000);

    // R9 enable gates irq
    wr(5'h00, 32'h00F0_0000);
    chk("R9 irq enabled", {31'd0, irq}, 32'd1);
    wr(5'h10, 32'hFFFF_FFFF);
    chk("R9 irq after clear", {31'd0, irq}, '0);

    // R4 rising on low half
    wr(5'h04, 32'h0000_FFFF);
    smp(32'h0F0F_00FF);
    step(1);
    chk("R4 rising", status, 32'h0000_00FF);
    smp(32'h0F0F_0000);
    step(1);
    chk("R4 falls ignored", status, 32'h0000_00FF);
    wr(5'h10, 32'hFFFF_FFFF);

    // R5 both edges, mode_a 1 on bits 4-7 and 0 on bits 20-23
    wr(5'h0C, 32'h00F0_00F0);
    smp(32'h0FFF_00F0);
    step(1);
    chk("R5 both up", status, 32'h00F0_00F0);
    chk("R9 irq both", {31'd0, irq}, 32'd1);
    wr(5'h10, 32'hFFFF_FFFF);
    smp(32'h0F0F_0000);
    step(1);
    chk("R5 both down", status, 32'h00F0_00F0);
    wr(5'h10, 32'hFFFF_FFFF);

    // R11 no sample, no edge
    step(3);
    chk("R11 idle", status, '0);

    // R6 level: bit0 high, bit1 low; held word 0F0F0000
    wr(5'h04, 32'h0000_FFFD);
    wr(5'h08, 32'h0000_0003);
    chk("R6 level not yet", status, '0);
    step(1);
    chk("R6 level low", status, 32'h0000_0002);
    wr(5'h10, 32'h0000_0002);
    chk("R8 level beats clear", status, 32'h0000_0002);
    smp(32'h0F0F_0001);
    step(1);
    chk("R6 level high", status, 32'h0000_0003);
    wr(5'h08, 32'h0000_0000);
    wr(5'h10, 32'h0000_0003);
    chk("R7 clear after level off", status, '0);

    // R8 edge and clear in the same cycle
    smp(32'h0F0E_0001);
    wr(5'h10, 32'h0001_0000);
    chk("R8 edge beats clear", status, 32'h0001_0000);
    wr(5'h10, 32'h0001_0000);
    chk("R7 clear edge bit", status, '0);

    // R2 map readback and unmapped writes
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h02, 32'hFFFF_FFFF);
    rd(5'h00, v); chk("R2 enable", v, 32'h00F0_0000);
    rd(5'h04, v); chk("R2 mode_a", v, 32'h0000_FFFD);
    rd(5'h08, v); chk("R2 mode_b", v, '0);
    rd(5'h0C, v); chk("R2 mode_c", v, 32'h00F0_00F0);
    rd(5'h14, v); chk("R2 unmapped read", v, '0);
    chk("R2 status untouched", status, '0);

    step(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    done = 1'b1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule